// File: doc/BRIEF.md
# Sensor Status and Command Controller

This block is the digital status and control core of a battery-buffered position sensor. It keeps an 8-bit sticky status byte. Error-monitor condition inputs set its bits, and software writes clear them. It also decodes single-byte commands written to a command address. The block drives an active-low error line, which can light an indicator, and an active-low battery warning line.

The block tracks three operating modes. In boot, a configuration reload has been requested and has not finished. In run, position reads are served. In sleep, position sensing is halted. A pulse on the preset pin, or a reboot command, starts boot and raises a level-held load request toward the configuration loader. Boot ends when the loader returns a done strobe. A sleep command halts sensing. The next register write of any kind ends sleep. That write is then carried out as usual. Reads never end sleep.

Top module: `sc_ctrl_core`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the block is in boot. The status byte reads 0x80, load_req_o=1, ready_o=0, err_n_o=0, sleep_o=0, wrn_n_o=1 and soft_rst_o=0.
- R2: Reading address 0x10 returns the status byte. A high cond_i[k] for k in 0..6 sets status bit k at the next clock edge. The bit stays set after the condition drops. Bit 7 marks a preset, reboot or sleep entry.
- R3: A write to 0x10 clears each status bit written as 0 and leaves each bit written as 1 unchanged. If a condition is high in the same cycle as the clear, its bit stays set.
- R4: Writing command 0x05 to address 0x11 clears all status bits, except those whose condition input is high in that cycle.
- R5: In run mode, err_n_o is low exactly when any of status bits 0 to 4 is set. Bits 5, 6 and 7 do not pull it low.
- R6: wrn_n_o is low exactly when status bit 5 is set.
- R7: A cycle with preset_i high enters boot from any mode and sets status bit 7. While in boot, load_req_o=1, ready_o=0 and err_n_o=0. The cycle after load_done_i is seen in boot, the block is in run, with ready_o=1 and load_req_o=0.
- R8: Command 0x03 (reboot) acts like a preset pulse: it enters boot, sets bit 7 and requests a reload.
- R9: Command 0x02 (soft reset) raises soft_rst_o for exactly one cycle, in the cycle after the write. It changes neither the status byte nor the mode.
- R10: Command 0x04 in run or sleep enters sleep. Sleep sets bit 7, and gives sleep_o=1, ready_o=0 and err_n_o=0. During boot the sleep command is ignored.
- R11: In sleep, cycles with reg_wr low keep the block asleep. Any write, to any address, leaves sleep and is then carried out. A sleep command written while asleep keeps the block asleep. Leaving sleep releases err_n_o, and bit 7 stays set.
- R12: Command codes 0x00, 0x01 and 0x06 to 0xFF change no state. Reading address 0x11, or any address other than 0x10, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| preset_i | input | 1 | Preset pin, high for a preset pulse |
| cond_i | input | 7 | Error-monitor conditions for status bits 0..6 |
| load_req_o | output | 1 | Configuration and preload reload request |
| load_done_i | input | 1 | Loader finished successfully |
| sleep_o | output | 1 | Position sensing halted |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| ready_o | output | 1 | Position read requests are served |
| err_n_o | output | 1 | Active-low error indication |
| wrn_n_o | output | 1 | Active-low battery early warning |

## Verification
The bench clears a bit while its condition is still held. A design where the clear beat the monitor would read 0x00 instead of 0x08. It walks the block through sleep with reads, then a repeated sleep command, then a write to an unused address. A design that woke on reads, ignored the repeated command, or cleared bit 7 on wake-up would show the wrong sleep_o or a wrong status byte. It issues a sleep command in the middle of boot. A design that accepted it would drop the load request. It also sends reserved and out-of-range command codes, which must leave every output and the status byte as they were.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int STAT_W    = 8;
    localparam int COND_W    = STAT_W - 1;
    localparam int ERR_BITS  = 5;
    localparam int BIT_WARN  = 5;
    localparam int BIT_BOOT  = 7;

    localparam logic [7:0] STATUS_ADDR = 8'h10;
    localparam logic [7:0] CMD_ADDR    = 8'h11;

    typedef enum logic [7:0] {
        CMD_RSV0     = 8'h00,
        CMD_RSV1     = 8'h01,
        CMD_SOFT_RST = 8'h02,
        CMD_REBOOT   = 8'h03,
        CMD_SLEEP    = 8'h04,
        CMD_SCLR     = 8'h05
    } cmd_code_e;

    typedef enum logic [1:0] {
        MODE_BOOT  = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_SLEEP = 2'd2
    } mode_e;

    typedef struct packed {
        logic any_wr;
        logic stat_wr;
        logic soft_rst;
        logic reboot;
        logic sleep;
        logic sclr;
    } req_t;

    function automatic logic [STAT_W-1:0] err_mask();
        logic [STAT_W-1:0] m;
        for (int i = 0; i < STAT_W; i++) m[i] = (i < ERR_BITS);
        return m;
    endfunction

endpackage

// File: rtl/sc_cmd_decode.sv
module sc_cmd_decode
    import sc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output req_t              req
);
    logic hit_cmd;
    assign hit_cmd = wr && (addr == ADDR_W'(CMD_ADDR));

    always_comb begin
        req         = '0;
        req.any_wr  = wr;
        req.stat_wr = wr && (addr == ADDR_W'(STATUS_ADDR));
        if (hit_cmd) begin
            case (wdata)
                8'(CMD_SOFT_RST): req.soft_rst = 1'b1;
                8'(CMD_REBOOT):   req.reboot   = 1'b1;
                8'(CMD_SLEEP):    req.sleep    = 1'b1;
                8'(CMD_SCLR):     req.sclr     = 1'b1;
                default:          ;
            endcase
        end
    end
endmodule

// File: rtl/sc_status_reg.sv
module sc_status_reg
    import sc_pkg::*;
#(
    parameter logic [STAT_W-1:0] RST_VAL = STAT_W'(1) << BIT_BOOT
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [7:0]        wdata,
    input  logic [STAT_W-1:0] set_vec,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] keep;

    always_comb begin
        if (req.sclr)         keep = '0;
        else if (req.stat_wr) keep = wdata[STAT_W-1:0];
        else                  keep = '1;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) status[b] <= RST_VAL[b];
            else     status[b] <= (status[b] & keep[b]) | set_vec[b];
        end
    end
endmodule

// File: rtl/sc_mode_fsm.sv
module sc_mode_fsm
    import sc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  preset,
    input  logic  load_done,
    input  req_t  req,
    output mode_e mode,
    output logic  boot_evt,
    output logic  soft_rst
);
    mode_e mode_n;
    logic  sleep_ok;

    assign sleep_ok = req.sleep && (mode != MODE_BOOT);
    assign boot_evt = preset || req.reboot || sleep_ok;

    always_comb begin
        mode_n = mode;
        if (preset || req.reboot) begin
            mode_n = MODE_BOOT;
        end else begin
            case (mode)
                MODE_BOOT:  if (load_done) mode_n = MODE_RUN;
                MODE_RUN:   if (req.sleep) mode_n = MODE_SLEEP;
                MODE_SLEEP: if (req.any_wr) mode_n = req.sleep ? MODE_SLEEP : MODE_RUN;
                default:    mode_n = MODE_BOOT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_BOOT;
            soft_rst <= 1'b0;
        end else begin
            mode     <= mode_n;
            soft_rst <= req.soft_rst;
        end
    end
endmodule

// File: rtl/sc_ctrl_core.sv
module sc_ctrl_core
    import sc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              preset_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              load_req_o,
    input  logic              load_done_i,
    output logic              sleep_o,
    output logic              soft_rst_o,
    output logic              ready_o,
    output logic              err_n_o,
    output logic              wrn_n_o
);
    localparam logic [STAT_W-1:0] ERR_MASK = err_mask();

    req_t              req;
    mode_e             mode;
    logic              boot_evt;
    logic [STAT_W-1:0] status_q;

    sc_cmd_decode #(.ADDR_W(ADDR_W)) i_dec (
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .req   (req)
    );

    sc_mode_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .preset    (preset_i),
        .load_done (load_done_i),
        .req       (req),
        .mode      (mode),
        .boot_evt  (boot_evt),
        .soft_rst  (soft_rst_o)
    );

    sc_status_reg i_stat (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (reg_wdata),
        .set_vec ({boot_evt, cond_i}),
        .status  (status_q)
    );

    assign reg_rdata  = (reg_addr == ADDR_W'(STATUS_ADDR)) ? status_q : 8'h00;
    assign load_req_o = (mode == MODE_BOOT);
    assign ready_o    = (mode == MODE_RUN);
    assign sleep_o    = (mode == MODE_SLEEP);
    assign err_n_o    = !((|(status_q & ERR_MASK)) || (mode != MODE_RUN));
    assign wrn_n_o    = !status_q[BIT_WARN];
endmodule

// File: rtl/sc_ctrl_core_chk.sv
module sc_ctrl_core_chk
    import sc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              preset_i,
    input logic [COND_W-1:0] cond_i,
    input logic              load_req_o,
    input logic              load_done_i,
    input logic              sleep_o,
    input logic              soft_rst_o,
    input logic              ready_o,
    input logic              err_n_o,
    input logic              wrn_n_o,
    input logic [STAT_W-1:0] status_q
);
    AST_COND_STICKS: assert property (@(posedge clk) disable iff (rst)
        (cond_i[2]) |=> status_q[2]); // R2
    AST_SCLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(CMD_ADDR) && reg_wdata == 8'h05 && cond_i == '0 && !preset_i)
        |=> (status_q == '0)); // R4
    AST_ERR_FROM_COND: assert property (@(posedge clk) disable iff (rst)
        (cond_i[4:0] != 5'd0) |=> !err_n_o); // R5
    AST_WARN_FROM_COND: assert property (@(posedge clk) disable iff (rst)
        cond_i[5] |=> !wrn_n_o); // R6
    AST_PRESET_BOOTS: assert property (@(posedge clk) disable iff (rst)
        preset_i |=> (load_req_o && !ready_o && status_q[7])); // R7
    AST_SOFT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(CMD_ADDR) && reg_wdata == 8'h02) |=> soft_rst_o); // R9
    AST_READ_KEEPS_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && !reg_wr && !preset_i) |=> sleep_o); // R11
    AST_WRITE_WAKES: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && reg_wr && reg_addr == ADDR_W'(STATUS_ADDR) && !preset_i) |=> ready_o); // R11
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(CMD_ADDR)) |-> (reg_rdata == 8'h00)); // R12
endmodule

bind sc_ctrl_core sc_ctrl_core_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .preset_i    (preset_i),
    .cond_i      (cond_i),
    .load_req_o  (load_req_o),
    .load_done_i (load_done_i),
    .sleep_o     (sleep_o),
    .soft_rst_o  (soft_rst_o),
    .ready_o     (ready_o),
    .err_n_o     (err_n_o),
    .wrn_n_o     (wrn_n_o),
    .status_q    (status_q)
);

// File: tb/test_sc_ctrl_core.sv
module test_sc_ctrl_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_CMD  = 8'h11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       preset_i = 1'b0;
    logic [6:0] cond_i = 7'd0;
    logic       load_req_o;
    logic       load_done_i = 1'b0;
    logic       sleep_o, soft_rst_o, ready_o, err_n_o, wrn_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_ctrl_core #(.ADDR_W(8)) i_sc_ctrl_core (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .preset_i(preset_i),
        .cond_i(cond_i), .load_req_o(load_req_o), .load_done_i(load_done_i),
        .sleep_o(sleep_o), .soft_rst_o(soft_rst_o), .ready_o(ready_o),
        .err_n_o(err_n_o), .wrn_n_o(wrn_n_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic rd_stat(output logic [7:0] v);
        reg_addr = A_STAT;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    endtask

    // packed outputs: {load_req, ready, sleep, soft_rst, err_n, wrn_n}
    function automatic logic [7:0] outs();
        return {2'b00, load_req_o, ready_o, sleep_o, soft_rst_o, err_n_o, wrn_n_o};
    endfunction

    task automatic finish_boot();
        load_done_i = 1'b1;
        @(negedge clk);
        load_done_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd_stat(s);
        check("R1 status", s, 8'h80);
        check("R1 outputs", outs(), 8'b0010_0001);
        finish_boot();
        check("R7 ready after load", outs(), 8'b0001_0011);
        wr(A_STAT, 8'h7F);
        rd_stat(s);
        check("R3 clear bit7", s, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] s;
        cond_i = 7'h04; @(negedge clk); cond_i = 7'h00;
        @(negedge clk);
        rd_stat(s);
        check("R2 sticky bit2", s, 8'h04);
        check("R5 err low", {7'd0, err_n_o}, 8'h00);
        wr(A_STAT, 8'hFB);
        rd_stat(s);
        check("R3 clear written zero", s, 8'h00);
        check("R5 err released", {7'd0, err_n_o}, 8'h01);
        cond_i = 7'h08; @(negedge clk);
        wr(A_STAT, 8'h00);
        rd_stat(s);
        check("R3 set wins over clear", s, 8'h08);
        cond_i = 7'h00;
        cond_i = 7'h01; @(negedge clk); cond_i = 7'h00;
        wr(A_STAT, 8'hF7);
        rd_stat(s);
        check("R3 ones keep bits", s, 8'h01);
        wr(A_STAT, 8'h00);
    endtask

    task automatic t_masks();
        logic [7:0] s;
        cond_i = 7'h40; @(negedge clk); cond_i = 7'h00;
        check("R5 bit6 not error", outs(), 8'b0001_0011);
        cond_i = 7'h20; @(negedge clk); cond_i = 7'h00;
        check("R6 warn low, err high", outs(), 8'b0001_0010);
        cond_i = 7'h10; @(negedge clk); cond_i = 7'h00;
        check("R5 bit4 error", {7'd0, err_n_o}, 8'h00);
        rd_stat(s);
        check("R2 layout", s, 8'h70);
        wr(A_CMD, 8'h05);
        rd_stat(s);
        check("R4 sclr", s, 8'h00);
        check("R6 warn released", outs(), 8'b0001_0011);
        cond_i = 7'h02; @(negedge clk);
        wr(A_CMD, 8'h05);
        cond_i = 7'h00;
        rd_stat(s);
        check("R4 active cond survives", s, 8'h02);
        wr(A_CMD, 8'h05);
    endtask

    task automatic t_soft();
        logic [7:0] s;
        cond_i = 7'h40; @(negedge clk); cond_i = 7'h00;
        wr(A_CMD, 8'h02);
        check("R9 pulse high", outs(), 8'b0001_0111);
        @(negedge clk);
        check("R9 pulse one cycle", outs(), 8'b0001_0011);
        rd_stat(s);
        check("R9 status kept", s, 8'h40);
        wr(A_STAT, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] s;
        logic [7:0] codes [4] = '{8'h00, 8'h01, 8'h06, 8'hFF};
        for (int i = 0; i < 4; i++) begin
            wr(A_CMD, codes[i]);
            check("R12 no-op outputs", outs(), 8'b0001_0011);
            rd_stat(s);
            check("R12 no-op status", s, 8'h00);
        end
        reg_addr = A_CMD; #1;
        check("R12 cmd reads zero", reg_rdata, 8'h00);
        reg_addr = 8'h33; #1;
        check("R12 other reads zero", reg_rdata, 8'h00);
        reg_addr = 8'h00;
    endtask

    task automatic t_sleep();
        logic [7:0] s;
        wr(A_CMD, 8'h04);
        check("R10 sleep entered", outs(), 8'b0000_1001);
        rd_stat(s);
        check("R10 bit7 set", s, 8'h80);
        for (int i = 0; i < 4; i++) begin
            reg_addr = 8'(A_STAT + 8'(i));
            @(negedge clk);
        end
        check("R11 reads keep sleep", outs(), 8'b0000_1001);
        wr(A_CMD, 8'h04);
        check("R11 sleep again stays", outs(), 8'b0000_1001);
        wr(8'h20, 8'h00);
        check("R11 any write wakes", outs(), 8'b0001_0011);
        rd_stat(s);
        check("R11 bit7 stays", s, 8'h80);
        wr(A_CMD, 8'h04);
        wr(A_CMD, 8'h05);
        rd_stat(s);
        check("R11 wake write executed", s, 8'h00);
        check("R11 awake after sclr", outs(), 8'b0001_0011);
    endtask

    task automatic t_reboot();
        logic [7:0] s;
        wr(A_CMD, 8'h03);
        check("R8 reboot boots", outs(), 8'b0010_0001);
        rd_stat(s);
        check("R8 bit7", s, 8'h80);
        wr(A_STAT, 8'h00);
        wr(A_CMD, 8'h04);
        check("R10 sleep ignored in boot", outs(), 8'b0010_0001);
        rd_stat(s);
        check("R10 no bit7 in boot", s, 8'h00);
        finish_boot();
        check("R7 run after done", outs(), 8'b0001_0011);
    endtask

    task automatic t_preset();
        logic [7:0] s;
        preset_i = 1'b1; @(negedge clk); preset_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 held in boot", outs(), 8'b0010_0001);
        rd_stat(s);
        check("R7 bit7", s, 8'h80);
        finish_boot();
        check("R7 released", outs(), 8'b0001_0011);
        wr(A_STAT, 8'h00);
        wr(A_CMD, 8'h04);
        preset_i = 1'b1; @(negedge clk); preset_i = 1'b0;
        check("R7 preset leaves sleep", outs(), 8'b0010_0001);
        finish_boot();
        wr(A_STAT, 8'h00);
        rd_stat(s);
        check("R7 final status", s, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sticky();
        t_masks();
        t_soft();
        t_reserved();
        t_sleep();
        t_reboot();
        t_preset();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule